// File: doc/BRIEF.md
# Display Access Slot Sequencer

This block produces the per-line access-slot timing for a tile-based video display controller. It runs on the master clock and cuts each scan line of 3420 master clocks into access slots. A slot is 20 master clocks in the narrow width mode and 16 in the wide width mode. It tracks the line number and the slot index within the line. At the first clock of each slot it classifies the slot: memory refresh, free for an external (CPU) access, or a background-colour fill request.

The width mode and the PAL/NTSC selection are captured once per frame, at the first master clock of line 0. The captured copy sets the slot length, the refresh pattern, the count of active lines and the frame length until the next frame starts. When the display is blanked, every non-refresh slot goes to external access. On active lines, every eighth slot in a fixed window also carries a fill request covering 16 pixels of the previous line, with its x position and the background colour index. The renderer and the memories sit outside this block and use these strobes.

Top module: `dslot_sequencer`

## Requirements
- R1: A line lasts LINE_CLKS (default 3420) master clocks. `line_num` counts lines from 0. After the last line of the frame it wraps to 0: NTSC_LINES (default 262) lines when the captured PAL bit is 0, PAL_LINES (default 313) when it is 1.
- R2: The slot length is 16 master clocks when the captured width bit is 1 (wide) and 20 when it is 0 (narrow). `slot_num` counts slots from 0 at the start of each line. `slot_start` is high on the first master clock of every slot. In wide mode the final slot of a line (slot 213) is cut short to 12 clocks.
- R3: On the first master clock of line 0, `cfg_wide` and `cfg_pal` are captured into `frame_wide` and `frame_pal`. Input changes at any other time have no effect on the outputs until the next frame starts.
- R4: `refresh_slot` is high at the start of slots 73, 105, 137, 169 and 201 in wide mode, and at the start of slots 66, 98, 130 and 162 in narrow mode. It is low at all other times.
- R5: `ext_slot` is high at the start of every non-refresh slot when `display_en` is 0, or when `line_num` is at or beyond the active count. The active count is NTSC_ACTIVE (default 225) when `frame_pal` is 0 and PAL_ACTIVE (default 241) when it is 1. A refresh slot never grants external access.
- R6: `fill_strobe` is high at the start of a slot when all of these hold: `display_en` is 0; `line_num` is between 1 and the active count minus 1; the slot lies in the fill window (55 to 207 wide, 48 to 168 narrow); and the slot minus the window start is a multiple of 8. During a fill strobe `fill_line` = `line_num` − 1 and `fill_color` = `bg_color`.
- R7: During a fill strobe, `fill_x` = ((slot − window start) with its low 4 bits cleared) × 2. `fill_x`, `fill_line` and `fill_color` are 0 whenever `fill_strobe` is low.
- R8: A synchronous active-high `rst` clears the line and slot counters and sets the captured mode to narrow NTSC (`frame_wide` = 0, `frame_pal` = 0).
- R9: When `display_en` is 1 on an active line, neither `ext_slot` nor `fill_strobe` fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | Width mode request, 1 = wide (16-clock slots) |
| cfg_pal | input | 1 | Frame standard request, 1 = PAL |
| display_en | input | 1 | Display enable; 0 blanks the display |
| bg_color | input | 6 | Background colour index |
| line_num | output | LINE_W (9) | Current line in the frame |
| slot_num | output | 8 | Slot index within the line |
| slot_start | output | 1 | First master clock of a slot |
| refresh_slot | output | 1 | Refresh slot strobe |
| ext_slot | output | 1 | External access slot strobe |
| fill_strobe | output | 1 | Background fill request |
| fill_x | output | 9 | First pixel of the 16-pixel fill span |
| fill_line | output | LINE_W (9) | Line the fill applies to |
| fill_color | output | 6 | Colour index for the fill |
| frame_wide | output | 1 | Width mode captured for this frame |
| frame_pal | output | 1 | PAL bit captured for this frame |

## Verification
The hardest case to reach is the frame boundary, where the captured mode changes the slot length, the refresh pattern and the frame length all at once. At full length a frame takes close to a million master clocks. The bench therefore shortens the frame and active line counts through parameters and keeps the 3420-clock line, so every slot position stays real. The stimulus changes the mode requests in the middle of a frame. This shows that nothing changes before line 0, and that the next frame switches slot length on its second clock. Several frames then run with the display blanked and unblanked, and in each the fill, refresh and external strobes are counted against closed-form totals.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    localparam int SLOT_W           = 8;
    localparam int WIDE_SLOT_CLKS   = 16;
    localparam int NARROW_SLOT_CLKS = 20;
    localparam int SUB_W            = $clog2(NARROW_SLOT_CLKS);
    localparam int FILL_X_W         = 9;
    localparam int COLOR_W          = 6;

    localparam logic [SLOT_W-1:0] WIDE_FILL_FIRST   = 8'd55;
    localparam logic [SLOT_W-1:0] WIDE_FILL_LAST    = 8'd207;
    localparam logic [SLOT_W-1:0] NARROW_FILL_FIRST = 8'd48;
    localparam logic [SLOT_W-1:0] NARROW_FILL_LAST  = 8'd168;

    typedef struct packed {
        logic wide;
        logic pal;
    } frame_mode_t;

    typedef struct packed {
        logic                start;
        logic                refresh;
        logic                ext;
        logic                fill;
        logic [FILL_X_W-1:0] fill_x;
    } slot_event_t;

    typedef struct packed {
        logic                hit;
        logic [FILL_X_W-1:0] x;
    } fill_pick_t;

    function automatic logic is_refresh_slot(input logic wide, input logic [SLOT_W-1:0] s);
        if (wide)
            return (s == 8'd73) || (s == 8'd105) || (s == 8'd137) ||
                   (s == 8'd169) || (s == 8'd201);
        else
            return (s == 8'd66) || (s == 8'd98) || (s == 8'd130) || (s == 8'd162);
    endfunction

    function automatic fill_pick_t pick_fill(input logic wide, input logic [SLOT_W-1:0] s);
        logic [SLOT_W-1:0] first;
        logic [SLOT_W-1:0] last;
        logic [SLOT_W-1:0] off;
        fill_pick_t        r;
        first = wide ? WIDE_FILL_FIRST : NARROW_FILL_FIRST;
        last  = wide ? WIDE_FILL_LAST  : NARROW_FILL_LAST;
        off   = s - first;
        r.hit = (s >= first) && (s <= last) && (off[2:0] == 3'b000);
        r.x   = {off[SLOT_W-1:4], 5'b00000};
        return r;
    endfunction

endpackage

// File: rtl/sqt_mode_latch.sv
module sqt_mode_latch
    import slot_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        capture,
    input  frame_mode_t req,
    output frame_mode_t cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= '{wide: 1'b0, pal: 1'b0};
        else if (capture)
            cur <= req;
    end
endmodule

// File: rtl/sqt_line_timer.sv
module sqt_line_timer
    import slot_seq_pkg::*;
#(
    parameter int LINE_CLKS  = 3420,
    parameter int NTSC_LINES = 262,
    parameter int PAL_LINES  = 313,
    parameter int LINE_W     = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_mode_t       mode,
    output logic [LINE_W-1:0] line,
    output logic [SLOT_W-1:0] slot,
    output logic              at_slot_start,
    output logic              at_frame_start
);
    localparam int POS_W = $clog2(LINE_CLKS);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_CLKS - 1);
    localparam logic [SUB_W-1:0] WIDE_SUB_LAST   = SUB_W'(WIDE_SLOT_CLKS - 1);
    localparam logic [SUB_W-1:0] NARROW_SUB_LAST = SUB_W'(NARROW_SLOT_CLKS - 1);
    localparam logic [LINE_W-1:0] NTSC_LAST_LINE = LINE_W'(NTSC_LINES - 1);
    localparam logic [LINE_W-1:0] PAL_LAST_LINE  = LINE_W'(PAL_LINES - 1);

    logic [POS_W-1:0]  pos;
    logic [SUB_W-1:0]  sub;
    logic [SUB_W-1:0]  sub_last;
    logic [LINE_W-1:0] line_last;

    always_comb begin
        sub_last  = mode.wide ? WIDE_SUB_LAST : NARROW_SUB_LAST;
        line_last = mode.pal  ? PAL_LAST_LINE : NTSC_LAST_LINE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            sub  <= '0;
            slot <= '0;
            line <= '0;
        end else if (pos == POS_LAST) begin
            pos  <= '0;
            sub  <= '0;
            slot <= '0;
            line <= (line == line_last) ? '0 : line + 1'b1;
        end else begin
            pos <= pos + 1'b1;
            if (sub == sub_last) begin
                sub  <= '0;
                slot <= slot + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    assign at_slot_start  = (sub == '0);
    assign at_frame_start = (pos == '0) && (line == '0);
endmodule

// File: rtl/sqt_slot_classifier.sv
module sqt_slot_classifier
    import slot_seq_pkg::*;
#(
    parameter int NTSC_ACTIVE = 225,
    parameter int PAL_ACTIVE  = 241,
    parameter int LINE_W      = 9
) (
    input  frame_mode_t       mode,
    input  logic [LINE_W-1:0] line,
    input  logic [SLOT_W-1:0] slot,
    input  logic              at_slot_start,
    input  logic              display_en,
    output slot_event_t       ev
);
    localparam logic [LINE_W-1:0] NTSC_ACT = LINE_W'(NTSC_ACTIVE);
    localparam logic [LINE_W-1:0] PAL_ACT  = LINE_W'(PAL_ACTIVE);

    logic       in_active;
    logic       rendering;
    fill_pick_t pick;

    always_comb begin
        in_active  = line < (mode.pal ? PAL_ACT : NTSC_ACT);
        rendering  = display_en && in_active;
        pick       = pick_fill(mode.wide, slot);
        ev.start   = at_slot_start;
        ev.refresh = at_slot_start && is_refresh_slot(mode.wide, slot);
        ev.ext     = at_slot_start && !ev.refresh && !rendering;
        ev.fill    = at_slot_start && !display_en && in_active &&
                     (line != '0) && pick.hit;
        ev.fill_x  = ev.fill ? pick.x : '0;
    end
endmodule

// File: rtl/dslot_sequencer.sv
module dslot_sequencer
    import slot_seq_pkg::*;
#(
    parameter int LINE_CLKS   = 3420,
    parameter int NTSC_LINES  = 262,
    parameter int PAL_LINES   = 313,
    parameter int NTSC_ACTIVE = 225,
    parameter int PAL_ACTIVE  = 241,
    localparam int MAX_LINES  = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
    localparam int LINE_W     = $clog2(MAX_LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wide,
    input  logic                cfg_pal,
    input  logic                display_en,
    input  logic [COLOR_W-1:0]  bg_color,
    output logic [LINE_W-1:0]   line_num,
    output logic [SLOT_W-1:0]   slot_num,
    output logic                slot_start,
    output logic                refresh_slot,
    output logic                ext_slot,
    output logic                fill_strobe,
    output logic [FILL_X_W-1:0] fill_x,
    output logic [LINE_W-1:0]   fill_line,
    output logic [COLOR_W-1:0]  fill_color,
    output logic                frame_wide,
    output logic                frame_pal
);
    frame_mode_t mode;
    frame_mode_t req;
    logic        frame_start;
    slot_event_t ev;

    assign req = '{wide: cfg_wide, pal: cfg_pal};

    sqt_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .capture (frame_start),
        .req     (req),
        .cur     (mode)
    );

    sqt_line_timer #(
        .LINE_CLKS  (LINE_CLKS),
        .NTSC_LINES (NTSC_LINES),
        .PAL_LINES  (PAL_LINES),
        .LINE_W     (LINE_W)
    ) u_timer (
        .clk            (clk),
        .rst            (rst),
        .mode           (mode),
        .line           (line_num),
        .slot           (slot_num),
        .at_slot_start  (slot_start),
        .at_frame_start (frame_start)
    );

    sqt_slot_classifier #(
        .NTSC_ACTIVE (NTSC_ACTIVE),
        .PAL_ACTIVE  (PAL_ACTIVE),
        .LINE_W      (LINE_W)
    ) u_class (
        .mode          (mode),
        .line          (line_num),
        .slot          (slot_num),
        .at_slot_start (slot_start),
        .display_en    (display_en),
        .ev            (ev)
    );

    always_comb begin
        refresh_slot = ev.refresh;
        ext_slot     = ev.ext;
        fill_strobe  = ev.fill;
        fill_x       = ev.fill_x;
        fill_line    = ev.fill ? line_num - 1'b1 : '0;
        fill_color   = ev.fill ? bg_color : '0;
        frame_wide   = mode.wide;
        frame_pal    = mode.pal;
    end
endmodule

// File: rtl/dslot_sequencer_checker.sv
module dslot_sequencer_checker #(
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              display_en,
    input logic [LINE_W-1:0] line_num,
    input logic [7:0]        slot_num,
    input logic              slot_start,
    input logic              refresh_slot,
    input logic              ext_slot,
    input logic              fill_strobe,
    input logic [8:0]        fill_x,
    input logic              frame_wide,
    input logic              frame_pal
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    // R1: the line number only moves at the first clock of a line
    a_r1_line_moves_at_start: assert property (@(posedge clk) disable iff (rst)
        armed && (line_num != $past(line_num)) |-> (slot_num == 8'd0) && slot_start);

    // R2: a new non-zero slot follows the previous slot index
    a_r2_slot_steps: assert property (@(posedge clk) disable iff (rst)
        armed && slot_start && (slot_num != 8'd0) |-> slot_num == $past(slot_num) + 8'd1);

    // R3: the captured mode changes only right after the frame's first clock
    a_r3_mode_held: assert property (@(posedge clk) disable iff (rst)
        armed && ({frame_wide, frame_pal} != $past({frame_wide, frame_pal}))
        |-> ($past(line_num) == '0) && ($past(slot_num) == 8'd0) && $past(slot_start));

    // R4: refresh only at a slot boundary
    a_r4_refresh_on_start: assert property (@(posedge clk) disable iff (rst)
        refresh_slot |-> slot_start);

    // R5: refresh slots never go to external access
    a_r5_no_ext_on_refresh: assert property (@(posedge clk) disable iff (rst)
        refresh_slot |-> !ext_slot);

    // R6: fill requests happen only on blanked, externally free slots
    a_r6_fill_on_blank: assert property (@(posedge clk) disable iff (rst)
        fill_strobe |-> ext_slot && !display_en);

    // R7: fill position is 32-pixel aligned
    a_r7_fill_x_aligned: assert property (@(posedge clk) disable iff (rst)
        fill_strobe |-> fill_x[4:0] == 5'd0);
endmodule

bind dslot_sequencer dslot_sequencer_checker #(.LINE_W(LINE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .display_en   (display_en),
    .line_num     (line_num),
    .slot_num     (slot_num),
    .slot_start   (slot_start),
    .refresh_slot (refresh_slot),
    .ext_slot     (ext_slot),
    .fill_strobe  (fill_strobe),
    .fill_x       (fill_x),
    .frame_wide   (frame_wide),
    .frame_pal    (frame_pal)
);

// File: tb/dslot_sequencer_test.sv
module dslot_sequencer_test;
    localparam int LC = 3420;
    localparam int N_ACT = 2;
    localparam int P_ACT = 3;
    localparam int N_LINES = 4;
    localparam int P_LINES = 5;
    localparam int LW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wide = 1'b0, cfg_pal = 1'b0, display_en = 1'b1;
    logic [5:0] bg_color = 6'h15;
    logic [LW-1:0] line_num, fill_line;
    logic [7:0] slot_num;
    logic slot_start, refresh_slot, ext_slot, fill_strobe, frame_wide, frame_pal;
    logic [8:0] fill_x;
    logic [5:0] fill_color;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dslot_sequencer #(.LINE_CLKS(LC), .NTSC_LINES(N_LINES), .PAL_LINES(P_LINES),
                      .NTSC_ACTIVE(N_ACT), .PAL_ACTIVE(P_ACT)) uut (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_pal(cfg_pal),
        .display_en(display_en), .bg_color(bg_color), .line_num(line_num),
        .slot_num(slot_num), .slot_start(slot_start), .refresh_slot(refresh_slot),
        .ext_slot(ext_slot), .fill_strobe(fill_strobe), .fill_x(fill_x),
        .fill_line(fill_line), .fill_color(fill_color), .frame_wide(frame_wide),
        .frame_pal(frame_pal));

    // behavioural reference: master clocks since frame start and captured mode
    int mc = 0;
    bit mw = 0, mp = 0;
    always @(posedge clk) begin
        if (rst) begin
            mc = 0; mw = 0; mp = 0;
        end else begin
            if (mc == 0) begin mw = cfg_wide; mp = cfg_pal; end
            mc = mc + 1;
            if (mc == LC * (mp ? P_LINES : N_LINES)) mc = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (mc=%0d)", req, act, exp, mc);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            int len, lc, ln, sl, act, fs, fe;
            bit st, rf, ex, fh;
            len = mw ? 16 : 20;
            lc = mc % LC; ln = mc / LC; sl = lc / len; st = (lc % len) == 0;
            rf = st && (mw ? (sl == 73 || sl == 105 || sl == 137 || sl == 169 || sl == 201)
                           : (sl == 66 || sl == 98 || sl == 130 || sl == 162));
            act = mp ? P_ACT : N_ACT;
            ex = st && !rf && (!display_en || ln >= act);
            fs = mw ? 55 : 48; fe = mw ? 207 : 168;
            fh = st && !display_en && ln > 0 && ln < act && sl >= fs && sl <= fe && ((sl - fs) % 8 == 0);
            chk("R1 line_num", int'(line_num), ln);
            chk("R2 slot_num", int'(slot_num), sl);
            chk("R2 slot_start", int'(slot_start), int'(st));
            chk("R3 frame_wide", int'(frame_wide), int'(mw));
            chk("R3 frame_pal", int'(frame_pal), int'(mp));
            chk("R4 refresh_slot", int'(refresh_slot), int'(rf));
            chk("R5 ext_slot", int'(ext_slot), int'(ex));
            chk("R6 fill_strobe", int'(fill_strobe), int'(fh));
            chk("R6 fill_line", int'(fill_line), fh ? ln - 1 : 0);
            chk("R6 fill_color", int'(fill_color), fh ? int'(bg_color) : 0);
            chk("R7 fill_x", int'(fill_x), fh ? ((sl - fs) / 16) * 32 : 0);
        end
    end

    // counts strobes over one whole frame starting at the next frame start
    task automatic count_frame(input string tag, input bit wide, input bit pal, input bit den);
        int nf, nr, ne, lines, act, spl, rpl, rs;
        nf = 0; nr = 0; ne = 0;
        do @(negedge clk); while (!(line_num == '0 && slot_num == 8'd0 && slot_start));
        lines = pal ? P_LINES : N_LINES;
        for (int i = 0; i < lines * LC; i++) begin
            if (i != 0) @(negedge clk);
            nf += int'(fill_strobe); nr += int'(refresh_slot); ne += int'(ext_slot);
        end
        act = pal ? P_ACT : N_ACT;
        spl = wide ? 214 : 171;
        rpl = wide ? 5 : 4;
        rs = den ? (lines - act) : lines;
        chk({tag, " R4 refresh count"}, nr, lines * rpl);
        chk({tag, " R5 ext count"}, ne, rs * (spl - rpl));
        chk({tag, " R6 fill count"}, nf, den ? 0 : (act - 1) * (wide ? 20 : 16));
    endtask

    task automatic set_in(input bit w, input bit p, input bit d);
        @(posedge clk); #2;
        cfg_wide = w; cfg_pal = p; display_en = d;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0; cmp_on = 1;
        @(negedge clk);
        chk("R8 reset line", int'(line_num), 0);
        chk("R8 reset slot", int'(slot_num), 0);
        chk("R8 reset mode", int'({frame_wide, frame_pal}), 0);
        // R9: narrow NTSC, display on
        count_frame("narrow ntsc on R9", 0, 0, 1);
        // R3: mid-frame request for wide has no effect until line 0
        repeat (5000) @(posedge clk);
        set_in(1, 0, 0);
        repeat (30) @(negedge clk);
        chk("R3 mid-frame hold", int'(frame_wide), 0);
        count_frame("wide ntsc off", 1, 0, 0);
        chk("R3 captured wide", int'(frame_wide), 1);
        set_in(1, 1, 0); bg_color = 6'h2A;
        count_frame("wide pal off", 1, 1, 0);
        set_in(0, 1, 1);
        count_frame("narrow pal on R9", 0, 1, 1);
        set_in(0, 0, 0);
        count_frame("narrow ntsc off", 0, 0, 0);
        // R8: reset in mid-frame
        set_in(1, 1, 0);
        repeat (4000) @(posedge clk);
        #2 rst = 1'b1;
        @(posedge clk); #2 rst = 1'b0;
        @(negedge clk);
        chk("R8 mid reset line", int'(line_num), 0);
        chk("R8 mid reset slot", int'(slot_num), 0);
        chk("R8 mid reset mode", int'({frame_wide, frame_pal}), 0);
        repeat (4000) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule